// File: doc/BRIEF.md
# Pushbutton Tuning Word Controller

This block turns three raw pushbuttons into the 24-bit tuning word of a numerically controlled oscillator. One outer button raises the word and the other lowers it. While the middle button is held, each step is fine rather than coarse. Holding an outer button repeats its step automatically. Pressing both outer buttons together returns the word to a fixed default near 137 kHz, assuming a 1.2 MHz sample rate.

Each button passes through a synchroniser and a debouncer. A small sequencer then merges the button activity into a single stream of commands: step up, step down or load default. A saturating accumulator applies the commands and raises a one-clock strobe whenever the word changes. All timing is counted in clock cycles, and every count is a parameter.

Top module: `tune_ctrl`

## Requirements
- R1: During reset and after it, `tune_word_o` holds DEF_WORD (1915398 by default) and `tune_stb_o` is low.
- R2: A press of the up button with the fine button released adds COARSE_STEP (280 by default) to the word.
- R3: A press of the down button subtracts the active step from the word.
- R4: While the fine button is held, an up or down step uses FINE_STEP (70 by default) in place of COARSE_STEP.
- R5: A raw button level that holds for fewer than DEB_CYC consecutive synchronised cycles has no effect on the word.
- R6: An outer button held alone repeats its step. The first repeat comes HOLD_CYC cycles after the first step, and later repeats come every RPT_CYC cycles.
- R7: A single outer button released before the COIN_CYC coincidence window ends still produces exactly one step.
- R8: If the second outer button arrives within COIN_CYC cycles of the first, the word loads DEF_WORD and no single step is taken. No further step occurs until both outer buttons are released.
- R9: The word saturates at 0 when stepping down and at 2^23-1 (8388607) when stepping up. It never wraps.
- R10: `tune_stb_o` is high for exactly the cycles in which the word has just changed. A command that leaves the word unchanged gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_up_i | input | 1 | Raw up button, active high |
| btn_dn_i | input | 1 | Raw down button, active high |
| btn_fine_i | input | 1 | Raw fine-step modifier button, active high |
| tune_word_o | output | 24 | Tuning word |
| tune_stb_o | output | 1 | One-cycle strobe on every change of the tuning word |

## Verification
A press reaches the sequencer after two synchroniser cycles plus DEB_CYC debounce cycles. The first step appears one register later, either when the coincidence window closes or when the button is released. That absolute latency is not pinned down, but the spacing of the repeats is exact. The first repeat strobe is due HOLD_CYC cycles after the first step and each later one RPT_CYC cycles after the one before. A scoreboard queues every expected word together with its required gap from the previous strobe, and a monitor checks each strobe against the queue on the falling clock edge. Any strobe that arrives with an empty queue counts as a failure, and so does any change of the word without a strobe. Buttons are released only once the queue has drained. The release latency is shorter than RPT_CYC, so no extra repeat can slip through.

// File: rtl/tune_pkg.sv
package tune_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_UP   = 2'd1,
    CMD_DN   = 2'd2,
    CMD_DEF  = 2'd3
  } tune_cmd_e;
endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned DEB_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o
);
  localparam int unsigned CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(DEB_CYC - 1);

  logic [1:0]    sync_q;
  logic          lvl_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LIM) begin
        lvl_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign level_o = lvl_q;

  AST_DEB_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> ($past(cnt_q) == LIM)); // R5
endmodule

// File: rtl/tune_seq.sv
module tune_seq
  import tune_pkg::*;
#(
  parameter int unsigned COIN_CYC = 8,
  parameter int unsigned HOLD_CYC = 40,
  parameter int unsigned RPT_CYC  = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      up_i,
  input  logic      dn_i,
  output tune_cmd_e cmd_o
);
  localparam int unsigned M1 = (COIN_CYC > HOLD_CYC) ? COIN_CYC : HOLD_CYC;
  localparam int unsigned CNT_MAX = (M1 > RPT_CYC) ? M1 : RPT_CYC;
  localparam int unsigned CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] COIN_LIM = CW'(COIN_CYC - 1);
  localparam logic [CW-1:0] HOLD_LIM = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] RPT_LIM  = CW'(RPT_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_HOLD, S_RPT, S_BOTH} seq_state_e;

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dir_q, dir_d;
  tune_cmd_e     cmd;
  logic          both, any;
  tune_cmd_e     held_step;

  assign both      = up_i & dn_i;
  assign any       = up_i | dn_i;
  assign held_step = up_i ? CMD_UP : CMD_DN;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CW'(1);
    dir_d   = dir_q;
    cmd     = CMD_NONE;
    unique case (state_q)
      S_IDLE: begin
        cnt_d = '0;
        if (both) begin
          cmd     = CMD_DEF;
          state_d = S_BOTH;
        end else if (any) begin
          dir_d   = up_i;
          state_d = S_WAIT;
        end
      end
      S_WAIT: begin
        if (both) begin
          cmd     = CMD_DEF;
          state_d = S_BOTH;
        end else if (!any) begin
          cmd     = dir_q ? CMD_UP : CMD_DN;  // short tap
          state_d = S_IDLE;
        end else if (cnt_q == COIN_LIM) begin
          cmd     = held_step;
          state_d = S_HOLD;
          cnt_d   = '0;
        end
      end
      S_HOLD, S_RPT: begin
        if (both) begin
          cmd     = CMD_DEF;
          state_d = S_BOTH;
        end else if (!any) begin
          state_d = S_IDLE;
        end else if (cnt_q == ((state_q == S_HOLD) ? HOLD_LIM : RPT_LIM)) begin
          cmd     = held_step;
          state_d = S_RPT;
          cnt_d   = '0;
        end
      end
      S_BOTH: begin
        if (!any) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dir_q   <= dir_d;
    end
  end

  assign cmd_o = cmd;

  AST_BOTH_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_BOTH) |-> (cmd_o != CMD_UP && cmd_o != CMD_DN)); // R8
  AST_WINDOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT) |-> (cnt_q <= COIN_LIM)); // R7
  AST_RPT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RPT && $past(state_q) == S_RPT && cnt_q != '0) |->
      (cnt_q == $past(cnt_q) + CW'(1))); // R6
endmodule

// File: rtl/tune_accum.sv
module tune_accum
  import tune_pkg::*;
#(
  parameter int unsigned W           = 24,
  parameter int unsigned COARSE_STEP = 280,
  parameter int unsigned FINE_STEP   = 70,
  parameter int unsigned DEF_WORD    = 1915398
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  tune_cmd_e    cmd_i,
  input  logic         fine_i,
  output logic [W-1:0] word_o,
  output logic         stb_o
);
  localparam logic [W-1:0] MAX_WORD = W'((64'd1 << (W - 1)) - 64'd1);
  localparam logic [W-1:0] DEF_W    = W'(DEF_WORD);

  logic [W-1:0] word_q, word_d, step;
  logic [W:0]   sum;
  logic         stb_q;

  assign step = fine_i ? W'(FINE_STEP) : W'(COARSE_STEP);
  assign sum  = {1'b0, word_q} + {1'b0, step};

  always_comb begin
    word_d = word_q;
    unique case (cmd_i)
      CMD_UP:  word_d = (sum > {1'b0, MAX_WORD}) ? MAX_WORD : sum[W-1:0];
      CMD_DN:  word_d = (word_q <= step) ? '0 : word_q - step;
      CMD_DEF: word_d = DEF_W;
      default: word_d = word_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= DEF_W;
      stb_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      stb_q  <= (word_d != word_q);
    end
  end

  assign word_o = word_q;
  assign stb_o  = stb_q;

  AST_WORD_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_q <= MAX_WORD); // R9
  AST_CHANGE_STROBED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_q != $past(word_q)) |-> stb_q); // R10
  AST_STROBE_CHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> (word_q != $past(word_q))); // R10
  AST_UP_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cmd_i) == CMD_UP && stb_q) |-> (word_q > $past(word_q))); // R2
  AST_DN_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cmd_i) == CMD_DN && stb_q) |-> (word_q < $past(word_q))); // R3
  AST_DEF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cmd_i) == CMD_DEF) |-> (word_q == DEF_W)); // R8
endmodule

// File: rtl/tune_ctrl.sv
module tune_ctrl
  import tune_pkg::*;
#(
  parameter int unsigned W           = 24,
  parameter int unsigned DEB_CYC     = 20000,
  parameter int unsigned COIN_CYC    = 2000,
  parameter int unsigned HOLD_CYC    = 500000,
  parameter int unsigned RPT_CYC     = 100000,
  parameter int unsigned COARSE_STEP = 280,
  parameter int unsigned FINE_STEP   = 70,
  parameter int unsigned DEF_WORD    = 1915398
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         btn_up_i,
  input  logic         btn_dn_i,
  input  logic         btn_fine_i,
  output logic [W-1:0] tune_word_o,
  output logic         tune_stb_o
);
  localparam int unsigned NBTN = 3;

  logic [NBTN-1:0] raw, lvl;
  tune_cmd_e       cmd;

  assign raw = {btn_fine_i, btn_dn_i, btn_up_i};

  for (genvar i = 0; i < NBTN; i++) begin : g_btn
    btn_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[i]),
      .level_o(lvl[i])
    );
  end

  tune_seq #(
    .COIN_CYC(COIN_CYC),
    .HOLD_CYC(HOLD_CYC),
    .RPT_CYC (RPT_CYC)
  ) u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .up_i  (lvl[0]),
    .dn_i  (lvl[1]),
    .cmd_o (cmd)
  );

  tune_accum #(
    .W          (W),
    .COARSE_STEP(COARSE_STEP),
    .FINE_STEP  (FINE_STEP),
    .DEF_WORD   (DEF_WORD)
  ) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cmd_i (cmd),
    .fine_i(lvl[2]),
    .word_o(tune_word_o),
    .stb_o (tune_stb_o)
  );
endmodule

// File: tb/tb_tune_ctrl.sv
module tb_tune_ctrl;
  localparam int unsigned W      = 24;
  localparam int unsigned DEB    = 4;
  localparam int unsigned COIN   = 8;
  localparam int unsigned HOLD   = 40;
  localparam int unsigned RPT    = 16;
  localparam int unsigned COARSE = 2000000;
  localparam int unsigned FINE   = 70;
  localparam int unsigned DEFW   = 1915398;
  localparam int unsigned MAXW   = 8388607;

  typedef struct {
    int unsigned word;
    int unsigned gap;
    string       req;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         btn_up = 1'b0, btn_dn = 1'b0, btn_fine = 1'b0;
  logic [W-1:0] word;
  logic         stb;

  int unsigned n_checks = 0, n_fail = 0, cyc = 0, last_stb = 0, model = DEFW;
  logic [W-1:0] prev_word = '0;
  bit           done = 1'b0;
  exp_t         sb_q[$];

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  tune_ctrl #(
    .W(W), .DEB_CYC(DEB), .COIN_CYC(COIN), .HOLD_CYC(HOLD), .RPT_CYC(RPT),
    .COARSE_STEP(COARSE), .FINE_STEP(FINE), .DEF_WORD(DEFW)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .btn_up_i(btn_up), .btn_dn_i(btn_dn),
    .btn_fine_i(btn_fine), .tune_word_o(word), .tune_stb_o(stb)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int unsigned w, input int unsigned gap, input string req);
    exp_t e;
    e.word = w; e.gap = gap; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (stb) begin
        if (sb_q.size() == 0) begin
          check("R10", "unexpected strobe word", longint'(word), -1);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(e.req, "strobed word", longint'(word), longint'(e.word));
          if (e.gap != 0) check("R6", "strobe gap", longint'(cyc - last_stb), longint'(e.gap));
        end
        last_stb = cyc;
      end else if (word != prev_word) begin
        check("R10", "word changed without strobe", longint'(word), longint'(prev_word));
      end
      prev_word = word;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic drain;
    while (sb_q.size() != 0) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // queue a held run: first step, then HOLD gap, then RPT gaps; stops at saturation
  task automatic plan_run(input bit up, input int unsigned step, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      int unsigned nx;
      if (up) nx = (model + step > MAXW) ? MAXW : model + step;
      else    nx = (model <= step) ? 0 : model - step;
      if (nx == model) break;
      push(nx, (i == 0) ? 0 : ((i == 1) ? HOLD : RPT), req);
      model = nx;
    end
  endtask

  initial begin
    idle(3);
    check("R1", "word in reset", longint'(word), DEFW);
    check("R1", "strobe in reset", longint'(stb), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    prev_word = word;
    idle(5);
    check("R1", "word after reset", longint'(word), DEFW);

    // R5: short glitch ignored
    btn_up = 1'b1; idle(2); btn_up = 1'b0;
    idle(60);
    check("R5", "word after glitch", longint'(word), model);

    // R4 R7: fine tap
    btn_fine = 1'b1; idle(20);
    model = model + FINE; push(model, 0, "R7");
    btn_up = 1'b1; idle(5); btn_up = 1'b0;
    drain(); idle(60);
    check("R4", "fine tap word", longint'(word), model);
    btn_fine = 1'b0; idle(20);

    // R2 R6 R9: coarse up held into ceiling
    plan_run(1'b1, COARSE, 10, "R2");
    btn_up = 1'b1; drain(); idle(100); btn_up = 1'b0; idle(40);
    check("R9", "ceiling", longint'(word), MAXW);

    // R3 R4 R6: fine down, three steps, released in time
    btn_fine = 1'b1; idle(20);
    plan_run(1'b0, FINE, 3, "R3");
    btn_dn = 1'b1; drain(); btn_dn = 1'b0; idle(80);
    check("R4", "after three fine downs", longint'(word), MAXW - 3 * FINE);
    btn_fine = 1'b0; idle(20);

    // R3 R9: coarse down into floor
    plan_run(1'b0, COARSE, 10, "R3");
    btn_dn = 1'b1; drain(); idle(100); btn_dn = 1'b0; idle(40);
    check("R9", "floor", longint'(word), 0);

    // R8: staggered both press loads default, stays silent while held
    model = DEFW; push(model, 0, "R8");
    btn_up = 1'b1; idle(3); btn_dn = 1'b1; idle(20);
    btn_up = 1'b0; idle(200);
    check("R8", "no step while one button remains", longint'(word), DEFW);
    btn_dn = 1'b0; idle(60);
    check("R8", "word after both release", longint'(word), DEFW);

    // R10: default load with no change gives no strobe
    btn_up = 1'b1; btn_dn = 1'b1; idle(60); btn_up = 1'b0; btn_dn = 1'b0; idle(60);
    check("R10", "word unchanged", longint'(word), DEFW);

    // R2: normal coarse tap afterwards
    model = DEFW + COARSE; push(model, 0, "R2");
    btn_up = 1'b1; idle(5); btn_up = 1'b0;
    drain(); idle(60);
    check("R2", "coarse tap word", longint'(word), model);
    check("R10", "scoreboard empty", longint'(sb_q.size()), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule